// File: doc/BRIEF.md
# Tagged Small-Integer Adder

This block speeds up integer addition in language runtimes that keep numbers either as small immediate values or as references to heap objects. Each operand is one 32-bit word. The top bit is a type flag: when it is set, the low 31 bits hold a two's-complement signed integer. When it is clear, those bits hold a pointer. The block returns a tagged sum only in the fast case: both operands are immediates and their 31-bit sum fits.

In every other case the block returns a word of all zeros and raises a fail flag. Software then falls back to its general routine. The zero word can never be mistaken for a valid result, because every valid result has its top bit set.

Operands enter with a valid strobe. A new pair can be accepted on every clock. Each result leaves a fixed number of cycles later with its own valid strobe. The data path has six register stages:

- capture the operands
- split each word into flag and payload
- combine the flags and add the payloads
- select on the flag check
- select on overflow
- register the output

Top module: `tsa_pipe`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `out_fail` are low until the first result emerges.
- R2: `out_valid` is `in_valid` delayed by exactly six rising clock edges, counting the edge that samples `in_valid`. The block accepts one operand pair per cycle with no gaps required.
- R3: If bit 31 of both operands is 1 and the 31-bit signed sum does not overflow, the result is `{1'b1, (op_a[30:0] + op_b[30:0]) mod 2^31}` and `out_fail` is 0.
- R4: If bit 31 of either operand is 0, the result is 32'h0000_0000 and `out_fail` is 1, whatever the payloads are.
- R5: If both operands are immediates and the payloads, read as signed 31-bit numbers, have a sum outside [-2^30, 2^30-1], the result is 32'h0000_0000 and `out_fail` is 1.
- R6: `out_fail` is high only together with `out_valid`, and only with an all-zero result word. Every non-failing valid result has bit 31 set.
- R7: In cycles where `out_valid` is low, `out_word` holds the last valid result and `out_fail` is 0.
- R8: Sums that wrap through zero with mixed signs are successes. For example, -1 + 1 yields 32'h8000_0000 with `out_fail` 0, distinct from the failure word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First tagged operand |
| op_b | input | 32 | Second tagged operand |
| out_valid | output | 1 | Result present this cycle |
| out_word | output | 32 | Tagged sum, or zero on failure |
| out_fail | output | 1 | Fast path refused for this result |

## Verification
The latency assertion assumes that `in_valid` is a clean 0 or 1 on every edge. It also assumes that reset stays asserted long enough for the internal release synchronizer to settle. The data assertions assume nothing about the operand words themselves, because any 32-bit pattern is a legal input.

The bench drives every input only on falling edges and holds reset for several cycles. It keeps the operand values defined in every cycle, including bubbles where `in_valid` is low, so that the pipeline never samples an undriven value.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

  localparam int unsigned TSA_LAT = 6;

  typedef struct packed {
    logic tag_ok;
    logic ovf;
  } tsa_flags_t;

endpackage

// File: rtl/tsa_rst_sync.sv
module tsa_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic meta_q;
  logic meta_d;

  always_comb begin
    meta_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q    <= 1'b0;
      rst_n_out <= 1'b0;
    end else begin
      meta_q    <= meta_d;
      rst_n_out <= meta_q;
    end
  end

endmodule

// File: rtl/tsa_unpack.sv
module tsa_unpack #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              direct_o,
  output logic [WORD_W-2:0] pay_o
);

  localparam int unsigned FLAG_BIT = WORD_W - 1;

  always_comb begin
    direct_o = word_i[FLAG_BIT];
    pay_o    = word_i[FLAG_BIT-1:0];
  end

endmodule

// File: rtl/tsa_add.sv
module tsa_add #(
  parameter int unsigned PAY_W = 31
) (
  input  logic [PAY_W-1:0] a_i,
  input  logic [PAY_W-1:0] b_i,
  output logic [PAY_W-1:0] sum_o,
  output logic             ovf_o
);

  localparam int unsigned SGN = PAY_W - 1;

  logic same_sign;

  always_comb begin
    sum_o     = a_i + b_i;
    same_sign = (a_i[SGN] == b_i[SGN]);
    ovf_o     = same_sign && (sum_o[SGN] != a_i[SGN]);
  end

endmodule

// File: rtl/tsa_select.sv
module tsa_select #(
  parameter int unsigned W = 32
) (
  input  logic         sel_i,
  input  logic [W-1:0] when1_i,
  input  logic [W-1:0] when0_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    if (sel_i) begin
      y_o = when1_i;
    end else begin
      y_o = when0_i;
    end
  end

endmodule

// File: rtl/tsa_pipe.sv
module tsa_pipe
  import tsa_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_fail
);

  localparam int unsigned PAY_W   = WORD_W - 1;
  localparam int unsigned CYC_W   = $clog2(TSA_LAT + 1);
  localparam logic [WORD_W-1:0] FAIL_WORD = '0;

  logic rst_q_n;

  tsa_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  // stage valid bits, index 1..6
  logic [TSA_LAT:1] v_q;
  logic [TSA_LAT:1] v_d;

  // stage 1: operand capture
  logic [WORD_W-1:0] a1_q, b1_q;

  // stage 2: flag and payload split
  logic             da2_q, db2_q;
  logic [PAY_W-1:0] pa2_q, pb2_q;
  logic             da2_d, db2_d;
  logic [PAY_W-1:0] pa2_d, pb2_d;

  // stage 3: flag combine and add
  tsa_flags_t       fl3_q, fl3_d;
  logic [PAY_W-1:0] sum3_q, sum3_d;

  // stage 4: tag select
  logic [WORD_W-1:0] w4_q, w4_d;
  tsa_flags_t        fl4_q;

  // stage 5: overflow select
  logic [WORD_W-1:0] w5_q, w5_d;
  logic              f5_q, f5_d;

  // stage 6: output
  logic [WORD_W-1:0] w6_q;
  logic              f6_q, f6_d;

  // ---------------- next-state logic ----------------
  always_comb begin
    v_d = {v_q[TSA_LAT-1:1], in_valid};
  end

  tsa_unpack #(.WORD_W(WORD_W)) i_unpack_a (
    .word_i (a1_q),
    .direct_o (da2_d),
    .pay_o  (pa2_d)
  );

  tsa_unpack #(.WORD_W(WORD_W)) i_unpack_b (
    .word_i (b1_q),
    .direct_o (db2_d),
    .pay_o  (pb2_d)
  );

  logic ovf3_raw;

  tsa_add #(.PAY_W(PAY_W)) i_add (
    .a_i   (pa2_q),
    .b_i   (pb2_q),
    .sum_o (sum3_d),
    .ovf_o (ovf3_raw)
  );

  always_comb begin
    fl3_d.tag_ok = da2_q & db2_q;
    fl3_d.ovf    = ovf3_raw;
  end

  tsa_select #(.W(WORD_W)) i_sel_tag (
    .sel_i   (fl3_q.tag_ok),
    .when1_i ({1'b1, sum3_q}),
    .when0_i (FAIL_WORD),
    .y_o     (w4_d)
  );

  tsa_select #(.W(WORD_W)) i_sel_ovf (
    .sel_i   (fl4_q.ovf),
    .when1_i (FAIL_WORD),
    .when0_i (w4_q),
    .y_o     (w5_d)
  );

  always_comb begin
    f5_d = (~fl4_q.tag_ok) | fl4_q.ovf;
    f6_d = v_q[5] & f5_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      v_q  <= '0;
      f6_q <= 1'b0;
    end else begin
      v_q  <= v_d;
      f6_q <= f6_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      a1_q <= op_a;
      b1_q <= op_b;
    end
  end

  always_ff @(posedge clk) begin
    if (v_q[1]) begin
      da2_q <= da2_d;
      db2_q <= db2_d;
      pa2_q <= pa2_d;
      pb2_q <= pb2_d;
    end
  end

  always_ff @(posedge clk) begin
    if (v_q[2]) begin
      fl3_q  <= fl3_d;
      sum3_q <= sum3_d;
    end
  end

  always_ff @(posedge clk) begin
    if (v_q[3]) begin
      w4_q  <= w4_d;
      fl4_q <= fl3_q;
    end
  end

  always_ff @(posedge clk) begin
    if (v_q[4]) begin
      w5_q <= w5_d;
      f5_q <= f5_d;
    end
  end

  always_ff @(posedge clk) begin
    if (v_q[5]) begin
      w6_q <= w5_q;
    end
  end

  always_comb begin
    out_valid = v_q[TSA_LAT];
    out_word  = w6_q;
    out_fail  = f6_q;
  end

  // ---------------- assertions ----------------
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cyc_q <= '0;
    end else if (cyc_q != CYC_W'(TSA_LAT)) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc_q == CYC_W'(TSA_LAT)) |-> (out_valid == $past(in_valid, TSA_LAT))); // R2

  AST_TAG_GATE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (v_q[4] && !fl4_q.tag_ok) |-> (w4_q == FAIL_WORD)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    (v_q[5] && !f5_q) |-> w5_q[WORD_W-1]); // R5

  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_fail |-> (out_valid && out_word == FAIL_WORD)); // R6

  AST_GOOD_TAGGED: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !out_fail) |-> out_word[WORD_W-1]); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !out_valid |-> ($stable(out_word) && !out_fail)); // R7

endmodule

// File: tb/test_tsa_pipe.sv
module test_tsa_pipe;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_fail;

  int n_checks;
  int n_errs;
  bit done;

  tsa_pipe i_tsa_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_fail  (out_fail)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: {fail, word}
  function automatic logic [32:0] ref_add(input logic [31:0] a, input logic [31:0] b);
    logic [30:0] s;
    logic        ov;
    s  = a[30:0] + b[30:0];
    ov = (a[30] == b[30]) && (s[30] != a[30]);
    if (!(a[31] && b[31]) || ov) return {1'b1, 32'h0};
    return {1'b0, 1'b1, s};
  endfunction

  task automatic run_one(input logic [31:0] a, input logic [31:0] b, input string req);
    logic [32:0] e;
    e = ref_add(a, b);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0; op_a = 32'h0; op_b = 32'h0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 early", {32'h0, out_valid}, 33'h0);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 on time", {32'h0, out_valid}, 33'h1);
    chk({out_fail, out_word} == e, req, {out_fail, out_word}, e);
    chk(!out_fail || out_word == 32'h0, "R6", {out_fail, out_word}, e);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; op_a = 32'h0; op_b = 32'h0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && out_fail == 1'b0, "R1 in reset", {31'h0, out_valid, out_fail}, 33'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_fail == 1'b0, "R1 after release", {31'h0, out_valid, out_fail}, 33'h0);
  endtask

  task automatic t_success();
    run_one(32'h8000_0005, 32'h8000_0007, "R3 small positive");
    run_one(32'h8000_1234, 32'hFFFF_FFF0, "R3 positive plus negative");
    run_one(32'hBFFF_FFFE, 32'h8000_0001, "R3 max positive no overflow");
    run_one(32'hFFFF_FFFF, 32'h8000_0001, "R8 minus one plus one");
    chk(out_word == 32'h8000_0000 && !out_fail, "R8 wrap value", {out_fail, out_word}, 33'h0_8000_0000);
  endtask

  task automatic t_tag_fail();
    run_one(32'h0000_0005, 32'h8000_0007, "R4 first is pointer");
    run_one(32'h8000_0005, 32'h7FFF_FFFF, "R4 second is pointer");
    run_one(32'h1234_5678, 32'h0000_0001, "R4 both pointers");
  endtask

  task automatic t_overflow();
    run_one(32'hBFFF_FFFF, 32'h8000_0001, "R5 positive overflow");
    run_one(32'hC000_0000, 32'hFFFF_FFFF, "R5 negative overflow");
    run_one(32'hC000_0000, 32'hC000_0000, "R5 most negative doubled");
  endtask

  task automatic t_stream();
    logic [31:0] sa [0:19];
    logic [31:0] sb [0:19];
    bit          sv [0:19];
    logic [32:0] last;
    bit          have_last;
    have_last = 1'b0;
    last = '0;
    for (int i = 0; i < 20; i++) begin
      sv[i] = !(i == 4 || i == 5 || i == 11 || i >= 16);
      sa[i] = 32'h8000_0000 | (32'(i) * 32'h0111_1111);
      sb[i] = (i % 3 == 0) ? 32'h0000_0009 : (32'h8000_0000 | 32'(i * 7));
    end
    for (int c = 0; c < 26; c++) begin
      @(negedge clk);
      if (c >= 6) begin
        int k;
        logic [32:0] e;
        k = c - 6;
        chk(out_valid == sv[k], "R2 stream valid", {32'h0, out_valid}, {32'h0, sv[k]});
        if (sv[k]) begin
          e = ref_add(sa[k], sb[k]);
          chk({out_fail, out_word} == e, "R3 R4 R5 stream data", {out_fail, out_word}, e);
          last = e; have_last = 1'b1;
        end else if (have_last) begin
          chk(!out_fail && out_word == last[31:0], "R7 hold in bubble", {out_fail, out_word}, {1'b0, last[31:0]});
        end
      end
      if (c < 20) begin
        in_valid = sv[c]; op_a = sa[c]; op_b = sb[c];
      end else begin
        in_valid = 1'b0; op_a = 32'h0; op_b = 32'h0;
      end
    end
  endtask

  initial begin
    n_checks = 0; n_errs = 0; done = 1'b0;
    t_reset();
    t_success();
    t_tag_fail();
    t_overflow();
    t_stream();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

endmodule